// File: doc/BRIEF.md
# RV32I Integer Arithmetic and Compare Unit

This block is the combinational integer datapath of a base 32-bit RISC-V core. It takes the raw instruction word and the two source register values, chooses the second operand itself, and returns the integer result. The integer operations are add, subtract, the three shifts, the two set-less-than forms and the three bitwise logic operations. Alongside the result it drives three compare flags (equal, signed less-than, unsigned less-than) for a separate branch unit.

A single 33-bit subtractor serves both the subtract result and all three flags. Add and subtract are told apart by instruction bit 5 as well as by instruction bit 30, so an immediate-form add with bit 30 set still adds. There are no clocks, no state and no latches. The outputs settle from the inputs in the same cycle.

Top module: `rv_int_alu`

## Requirements
- R1: When instruction bits [14:12] are 000 and not both instruction bit 30 and bit 5 are 1, the result is rs1 plus the second operand, modulo 2^32.
- R2: When bits [14:12] are 000 and both instruction bit 30 and bit 5 are 1, the result is rs1 minus the second operand. The immediate arithmetic opcode (bits [6:0] = 0010011, so bit 5 = 0) always adds, whatever bit 30 holds.
- R3: The second operand is rs2 when bits [6:0] are 0110011 (register form) or 1100011 (branch). For every other opcode it is instruction bits [31:20], sign-extended from bit 31.
- R4: Bits [14:12] = 001 gives rs1 shifted left with zero fill. The shift amount is rs2[4:0] for the register form and instruction bits [24:20] otherwise.
- R5: Bits [14:12] = 101 gives rs1 shifted right by the same shift amount as R4. The fill is the sign bit when instruction bit 30 is 1 and zero when it is 0.
- R6: Bits [14:12] = 010 gives signed less-than and 011 gives unsigned less-than of rs1 against the second operand. The outcome is placed in result bit 0 and bits [31:1] are zero.
- R7: Bits [14:12] = 100, 110 and 111 give bitwise XOR, OR and AND of rs1 and the second operand.
- R8: For every instruction, the three flags compare rs1 with the selected second operand. The equal flag means the two are equal, the unsigned flag means rs1 < operand unsigned, and the signed flag means rs1 < operand in two's complement.
- R9: When the two operands differ in bit 31, the signed flag equals rs1 bit 31 and the unsigned flag is its inverse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Raw instruction word |
| op_a_i | input | 32 | First source register value (rs1) |
| op_b_i | input | 32 | Second source register value (rs2) |
| result_o | output | 32 | Integer result |
| eq_o | output | 1 | rs1 equals the selected second operand |
| lt_o | output | 1 | rs1 less than the operand, signed |
| ltu_o | output | 1 | rs1 less than the operand, unsigned |

## Verification
The bench targets the operand values 0, 1, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF in every pairing. It drives these through every operation in register, immediate and branch form, then adds seeded random traffic.

Each wrong design shows up in a specific case:
- A signed compare that trusts the borrow bit alone reports 0x80000000 as larger than 0x7FFFFFFF.
- A subtract select that ignores bit 5 turns an immediate add with a large immediate into a subtract.
- A shift that always reads rs2 gives the wrong distance for immediate shifts.
- An arithmetic shift with the wrong fill shows zeros above negative values.
- Immediates that are not sign-extended break adds of 0x800 to 0xFFF.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int INSN_W = 32;

    localparam logic [6:0] OPC_REG    = 7'b0110011;
    localparam logic [6:0] OPC_BRANCH = 7'b1100011;

    // Operation selector; values match instruction bits [14:12]
    typedef enum logic [2:0] {
        FN_ADD  = 3'b000,
        FN_SLL  = 3'b001,
        FN_SLT  = 3'b010,
        FN_SLTU = 3'b011,
        FN_XOR  = 3'b100,
        FN_SR   = 3'b101,
        FN_OR   = 3'b110,
        FN_AND  = 3'b111
    } alu_fn_e;

    typedef struct packed {
        alu_fn_e fn;
        logic    use_rs2;     // second operand from register
        logic    amt_reg;     // shift distance from register
        logic    subtract;
        logic    arith;       // sign fill on right shift
    } alu_ctrl_t;
endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [11:0]     hi_field_i,   // instruction bits [31:20]
    input  logic [2:0]      fn_field_i,   // instruction bits [14:12]
    input  logic [6:0]      opc_i,        // instruction bits [6:0]
    output alu_ctrl_t       ctrl_o,
    output logic [XLEN-1:0] imm_o
);
    localparam int IMM_W = 12;

    alu_ctrl_t ctrl_d;

    always_comb begin
        ctrl_d.fn       = alu_fn_e'(fn_field_i);
        ctrl_d.use_rs2  = (opc_i == OPC_REG) || (opc_i == OPC_BRANCH);
        ctrl_d.amt_reg  = (opc_i == OPC_REG);
        // bit 10 of the high field is instruction bit 30
        ctrl_d.subtract = hi_field_i[10] & opc_i[5];
        ctrl_d.arith    = hi_field_i[10];
    end

    assign ctrl_o = ctrl_d;
    assign imm_o  = {{(XLEN-IMM_W){hi_field_i[IMM_W-1]}}, hi_field_i};
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    output logic [XLEN-1:0] diff_o,
    output logic            eq_o,
    output logic            lt_o,
    output logic            ltu_o
);
    localparam int WIDE = XLEN + 1;

    logic [WIDE-1:0] wide_d;

    always_comb begin
        wide_d = {1'b1, ~b_i} + {1'b0, a_i} + WIDE'(1);
    end

    assign diff_o = wide_d[XLEN-1:0];
    assign eq_o   = (wide_d[XLEN-1:0] == '0);
    assign ltu_o  = wide_d[XLEN];
    assign lt_o   = (a_i[XLEN-1] ^ b_i[XLEN-1]) ? a_i[XLEN-1] : wide_d[XLEN];
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int XLEN = 32,
    parameter int SHW  = $clog2(XLEN)
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [SHW-1:0]  amt_i,
    input  logic            right_i,
    input  logic            arith_i,
    output logic [XLEN-1:0] y_o
);
    logic [XLEN-1:0]          src;
    logic [SHW:0][XLEN-1:0]   stg;
    logic                     fill;

    assign fill = right_i & arith_i & a_i[XLEN-1];

    // left shifts run through the right shifter with reversed bits
    for (genvar gi = 0; gi < XLEN; gi++) begin : g_rev_in
        assign src[gi] = right_i ? a_i[gi] : a_i[XLEN-1-gi];
    end

    assign stg[0] = src;

    for (genvar gk = 0; gk < SHW; gk++) begin : g_stage
        localparam int STEP = 1 << gk;
        assign stg[gk+1] = amt_i[gk] ? {{STEP{fill}}, stg[gk][XLEN-1:STEP]}
                                     : stg[gk];
    end

    for (genvar go = 0; go < XLEN; go++) begin : g_rev_out
        assign y_o[go] = right_i ? stg[SHW][go] : stg[SHW][XLEN-1-go];
    end
endmodule

// File: rtl/rv_int_alu.sv
module rv_int_alu
    import alu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [INSN_W-1:0] instr_i,
    input  logic [XLEN-1:0]   op_a_i,
    input  logic [XLEN-1:0]   op_b_i,
    output logic [XLEN-1:0]   result_o,
    output logic              eq_o,
    output logic              lt_o,
    output logic              ltu_o
);
    localparam int SHW = $clog2(XLEN);

    typedef struct packed {
        logic [XLEN-1:0] result;
        logic            eq;
        logic            lt;
        logic            ltu;
    } alu_out_t;

    alu_ctrl_t       ctrl;
    logic [XLEN-1:0] imm;
    logic [XLEN-1:0] opnd2;
    logic [SHW-1:0]  shamt;
    logic [XLEN-1:0] diff;
    logic [XLEN-1:0] shifted;
    logic            cmp_eq;
    logic            cmp_lt;
    logic            cmp_ltu;
    logic            unused_fields;
    alu_out_t        out_d;

    assign unused_fields = ^{instr_i[19:15], instr_i[11:7]};

    alu_decode #(.XLEN(XLEN)) u_decode (
        .hi_field_i (instr_i[31:20]),
        .fn_field_i (instr_i[14:12]),
        .opc_i      (instr_i[6:0]),
        .ctrl_o     (ctrl),
        .imm_o      (imm)
    );

    assign opnd2 = ctrl.use_rs2 ? op_b_i : imm;
    assign shamt = ctrl.amt_reg ? op_b_i[SHW-1:0] : instr_i[20 +: SHW];

    alu_cmp #(.XLEN(XLEN)) u_cmp (
        .a_i    (op_a_i),
        .b_i    (opnd2),
        .diff_o (diff),
        .eq_o   (cmp_eq),
        .lt_o   (cmp_lt),
        .ltu_o  (cmp_ltu)
    );

    alu_shift #(.XLEN(XLEN), .SHW(SHW)) u_shift (
        .a_i     (op_a_i),
        .amt_i   (shamt),
        .right_i (ctrl.fn == FN_SR),
        .arith_i (ctrl.arith),
        .y_o     (shifted)
    );

    always_comb begin
        out_d.eq  = cmp_eq;
        out_d.lt  = cmp_lt;
        out_d.ltu = cmp_ltu;
        unique case (ctrl.fn)
            FN_ADD:  out_d.result = ctrl.subtract ? diff : (op_a_i + opnd2);
            FN_SLL:  out_d.result = shifted;
            FN_SLT:  out_d.result = {{(XLEN-1){1'b0}}, cmp_lt};
            FN_SLTU: out_d.result = {{(XLEN-1){1'b0}}, cmp_ltu};
            FN_XOR:  out_d.result = op_a_i ^ opnd2;
            FN_SR:   out_d.result = shifted;
            FN_OR:   out_d.result = op_a_i | opnd2;
            FN_AND:  out_d.result = op_a_i & opnd2;
            default: out_d.result = '0;
        endcase
    end

    assign result_o = out_d.result;
    assign eq_o     = out_d.eq;
    assign lt_o     = out_d.lt;
    assign ltu_o    = out_d.ltu;
endmodule

// File: rtl/rv_int_alu_chk.sv
module rv_int_alu_chk #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr,
    input logic [XLEN-1:0] op_a,
    input logic [XLEN-1:0] opnd2,
    input logic [XLEN-1:0] result,
    input logic            eq,
    input logic            lt,
    input logic            ltu
);
    always_comb begin
        if (!$isunknown({instr, op_a, opnd2, result, eq, lt, ltu})) begin
            // R8: equality excludes both orderings
            p_eq_excludes_lt_r8: assert (!(eq && (lt || ltu)));
            // R9: mixed signs make signed and unsigned orderings disagree
            p_sign_split_r9: assert ((op_a[XLEN-1] == opnd2[XLEN-1]) || (lt != ltu));
            // R6: set-less-than results are zero-extended
            p_slt_zext_r6: assert (!(instr[14:13] == 2'b01) ||
                                   (result[XLEN-1:1] == '0 &&
                                    result[0] == (instr[12] ? ltu : lt)));
            // R7: xor is zero exactly when operands are equal
            p_xor_zero_r7: assert (!(instr[14:12] == 3'b100) || ((result == '0) == eq));
            // R2: a subtract is zero exactly when operands are equal
            p_sub_zero_r2: assert (!(instr[14:12] == 3'b000 && instr[30] && instr[5]) ||
                                   ((result == '0) == eq));
        end
    end
endmodule

bind rv_int_alu rv_int_alu_chk #(.XLEN(XLEN)) u_chk (
    .instr  (instr_i),
    .op_a   (op_a_i),
    .opnd2  (opnd2),
    .result (result_o),
    .eq     (eq_o),
    .lt     (lt_o),
    .ltu    (ltu_o)
);

// File: tb/rv_int_alu_bench.sv
`timescale 1ns/1ps
module rv_int_alu_bench;
    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] result;
    logic        eq, lt, ltu;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #2.5 clk = ~clk;

    rv_int_alu u_rv_int_alu (
        .instr_i  (instr),
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .result_o (result),
        .eq_o     (eq),
        .lt_o     (lt),
        .ltu_o    (ltu)
    );

    function automatic logic [31:0] mk_reg(logic [2:0] f3, logic b30);
        return {1'b0, b30, 5'd0, 5'd2, 5'd1, f3, 5'd3, 7'b0110011};
    endfunction

    function automatic logic [31:0] mk_imm(logic [2:0] f3, logic [11:0] imm);
        return {imm, 5'd1, f3, 5'd3, 7'b0010011};
    endfunction

    function automatic logic [31:0] mk_br(logic [2:0] f3);
        return {7'd0, 5'd2, 5'd1, f3, 5'd0, 7'b1100011};
    endfunction

    function automatic logic [31:0] mk_load(logic [11:0] imm);
        return {imm, 5'd1, 3'b010, 5'd3, 7'b0000011};
    endfunction

    function automatic logic [31:0] second(logic [31:0] ins, logic [31:0] b);
        if (ins[6:0] == 7'b0110011 || ins[6:0] == 7'b1100011) return b;
        return {{20{ins[31]}}, ins[31:20]};
    endfunction

    function automatic logic [31:0] ref_result(logic [31:0] ins, logic [31:0] a, logic [31:0] b);
        logic [31:0] b2 = second(ins, b);
        int unsigned sh = (ins[6:0] == 7'b0110011) ? int'(b[4:0]) : int'(ins[24:20]);
        case (ins[14:12])
            3'd0: return (ins[30] && ins[5]) ? a - b2 : a + b2;
            3'd1: return a << sh;
            3'd2: return ($signed(a) < $signed(b2)) ? 32'd1 : 32'd0;
            3'd3: return (a < b2) ? 32'd1 : 32'd0;
            3'd4: return a ^ b2;
            3'd5: return ins[30] ? 32'($signed(a) >>> sh) : a >> sh;
            3'd6: return a | b2;
            default: return a & b2;
        endcase
    endfunction

    function automatic string res_tag(logic [31:0] ins);
        case (ins[14:12])
            3'd0: return (ins[30] && ins[5]) ? "R2" : "R1";
            3'd1: return "R4";
            3'd5: return "R5";
            3'd2, 3'd3: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s instr=%h a=%h b=%h actual=%h expected=%h",
                     tag, instr, op_a, op_b, act, exp);
        end
    endtask

    task automatic run(logic [31:0] ins, logic [31:0] a, logic [31:0] b, string rtag = "");
        logic [31:0] b2;
        logic [2:0]  fl;
        @(negedge clk);
        instr = ins; op_a = a; op_b = b;
        #1;
        b2 = second(ins, b);
        fl = {a == b2, $signed(a) < $signed(b2), a < b2};
        chk((rtag == "") ? res_tag(ins) : rtag, result, ref_result(ins, a, b));
        chk((a[31] != b2[31]) ? "R9" : "R8", {29'd0, eq, lt, ltu}, {29'd0, fl});
    endtask

    initial begin
        logic [31:0] corner [5] = '{32'h0, 32'h1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF};
        logic [11:0] icorn  [4] = '{12'h000, 12'h7FF, 12'h800, 12'hFFF};
        void'($urandom(32'd20240611));
        instr = '0; op_a = '0; op_b = '0;

        // idle-like all-zero word: immediate add of zero, operands equal
        run(32'h0, 32'h0, 32'h0, "R1");

        // directed: R3 sign-extended immediate add
        run(mk_imm(3'd0, 12'hFFF), 32'd5, 32'hDEAD, "R3");
        // R2: immediate add with bit 30 set must still add
        run(mk_imm(3'd0, 12'h400), 32'd10, 32'd0, "R2");
        // R2: register subtract 0 - 1
        run(mk_reg(3'd0, 1'b1), 32'd0, 32'd1, "R2");
        // R3: load opcode takes the immediate, branch takes rs2
        run(mk_load(12'h800), 32'h1000, 32'h5, "R3");
        run(mk_br(3'd0), 32'h12345678, 32'h12345678, "R3");
        // R4: immediate shift distance from the instruction, not rs2
        run(mk_imm(3'd1, 12'd31), 32'h1, 32'h0, "R4");
        // R5: arithmetic immediate shift of a negative value
        run(mk_imm(3'd5, {7'b0100000, 5'd4}), 32'h80000000, 32'h3, "R5");
        // R9: signed compare across the sign boundary
        run(mk_br(3'd4), 32'h80000000, 32'h7FFFFFFF, "R9");

        // corner pairs in register form, every operation, both bit-30 values
        for (int f = 0; f < 8; f++)
            for (int s = 0; s < 2; s++)
                for (int i = 0; i < 5; i++)
                    for (int j = 0; j < 5; j++)
                        run(mk_reg(3'(f), s[0]), corner[i], corner[j]);

        // corner operands against corner immediates
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 4; j++)
                    run(mk_imm(3'(f), icorn[j]), corner[i], 32'hA5A5A5A5);

        // branch forms with corner pairs
        for (int f = 0; f < 8; f++)
            for (int i = 0; i < 5; i++)
                for (int j = 0; j < 5; j++)
                    run(mk_br(3'(f)), corner[i], corner[j]);

        // seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] ins;
            int unsigned kind = $urandom_range(0, 3);
            logic [2:0]  f3 = 3'($urandom);
            case (kind)
                0: ins = mk_reg(f3, 1'($urandom));
                1: ins = mk_imm(f3, 12'($urandom));
                2: ins = mk_br(f3);
                default: ins = mk_load(12'($urandom));
            endcase
            run(ins, $urandom, $urandom);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule